// File: doc/BRIEF.md
# Receive Polarity Detect and Lock

This block sits in the receive path of a 10 Mb/s twisted-pair port. It works out whether the differential receive pair was wired with its two legs swapped, and it flips the recovered data back to true polarity. Upstream logic qualifies link pulses and packets; this block sees only their results. A strobe with a sensed sign marks each normal link pulse that upstream logic accepts. A second strobe with its own sign marks the end of each valid packet. A level reports whether the link is established.

The first link pulse after the block starts, or after a link loss, picks the initial polarity. Each received packet then either confirms the current choice or overrides it. A run of agreeing packets of configurable length (two by default) freezes the choice. The choice stays frozen until the link drops. A link loss puts the block back in its unlocked, undecided state.

Receive data flows through a valid/ready stream with no added latency. `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. A beat moves only when both valid and ready are high. The block never holds data and never stalls on its own, so back-pressure reaches the source unchanged. The polarity and lock flags are plain level outputs.

Top module: `rx_polarity_lock`

## Requirements
- R1: Out of reset, `pol_inv` is 0, `pol_locked` is 0 and the block is undecided.
- R2: In the undecided state, a link pulse strobe sets `pol_inv` to the pulse's sign on the next clock edge (sign 1 means the pair is inverted). Link pulses that arrive once a decision exists leave `pol_inv` unchanged.
- R3: In the undecided state, a packet-end strobe decides the polarity from the packet's sign and counts as the first agreeing packet.
- R4: A packet whose sign equals `pol_inv` adds one to the agreeing-packet count, which saturates at LOCK_PKTS. `pol_locked` goes high on the clock edge where the count reaches LOCK_PKTS while `link_up` is 1.
- R5: An unlocked packet whose sign differs from `pol_inv` sets `pol_inv` to that sign and resets the agreeing-packet count to zero.
- R6: While `pol_locked` is 1 and `link_up` stays 1, both strobes are ignored, and `pol_inv` and `pol_locked` do not change.
- R7: A 1-to-0 transition of `link_up` clears `pol_locked` and `pol_inv` and returns the block to the undecided state. Strobes in that same cycle are ignored.
- R8: When both strobes occur in one cycle, only the packet strobe acts.
- R9: `out_data` equals `in_data` XOR `pol_inv` on every lane in the same cycle. `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.
- R10: If the count reaches LOCK_PKTS while `link_up` is 0, the block locks on the first clock edge at which `link_up` is 1, provided no disagreeing packet arrived in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link established level |
| nlp_stb | input | 1 | Normal link pulse detected, one cycle |
| nlp_neg | input | 1 | Sensed sign of that pulse, 1 = inverted |
| pkt_stb | input | 1 | Valid packet ended, one cycle |
| pkt_neg | input | 1 | Sensed sign of that packet, 1 = inverted |
| in_valid | input | 1 | Receive data beat valid |
| in_ready | output | 1 | Receive data beat accepted |
| in_data | input | DATA_W | Raw receive data |
| out_valid | output | 1 | Corrected data valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Corrected receive data |
| pol_inv | output | 1 | Current polarity setting, 1 = inverted |
| pol_locked | output | 1 | Polarity setting frozen |

## Verification
The bench builds the block with LOCK_PKTS = 2 and DATA_W = 2. A short lock window lets random packet strobes lock, break and re-lock the setting many times in one run. Two data lanes show that the correction is applied to every lane rather than to bit 0 alone. Link drops are rare but do occur, so the random run reaches locks that happen while the link is down (R10), link losses that coincide with strobes, and cycles in which both strobes fire together.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  typedef enum logic [1:0] {
    POL_UNDECIDED = 2'd0,
    POL_TRACKING  = 2'd1,
    POL_HELD      = 2'd2
  } pol_state_e;
endpackage

// File: rtl/rxpol_evt.sv
// Event decode: detects link loss and arbitrates the two strobes.
module rxpol_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic nlp_stb,
  input  logic pkt_stb,
  output logic link_fall,
  output logic pkt_evt,
  output logic nlp_evt
);
  logic link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  always_comb begin
    link_fall = link_q & ~link_up;
    // link loss swallows strobes; a packet outranks a link pulse
    pkt_evt   = pkt_stb & ~link_fall;
    nlp_evt   = nlp_stb & ~pkt_stb & ~link_fall;
  end
endmodule

// File: rtl/rxpol_ctrl.sv
// Polarity decision, agreeing-packet count and lock.
module rxpol_ctrl
  import rxpol_pkg::*;
#(
  parameter int LOCK_PKTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic link_fall,
  input  logic nlp_evt,
  input  logic nlp_neg,
  input  logic pkt_evt,
  input  logic pkt_neg,
  output logic inv,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_PKTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_PKTS);

  pol_state_e       state_q, state_d;
  logic             inv_q, inv_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    inv_d   = inv_q;
    cnt_d   = cnt_q;
    if (link_fall) begin
      state_d = POL_UNDECIDED;
      inv_d   = 1'b0;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        POL_UNDECIDED: begin
          if (pkt_evt) begin
            state_d = POL_TRACKING;
            inv_d   = pkt_neg;
            cnt_d   = CNT_W'(1);
          end else if (nlp_evt) begin
            state_d = POL_TRACKING;
            inv_d   = nlp_neg;
          end
        end
        POL_TRACKING: begin
          if (pkt_evt) begin
            if (pkt_neg == inv_q) begin
              if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
            end else begin
              inv_d = pkt_neg;
              cnt_d = '0;
            end
          end
        end
        POL_HELD: ;
        default: state_d = POL_UNDECIDED;
      endcase
      if (state_d == POL_TRACKING && cnt_d == CNT_MAX && link_up)
        state_d = POL_HELD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= POL_UNDECIDED;
      inv_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      inv_q   <= inv_d;
      cnt_q   <= cnt_d;
    end
  end

  assign inv    = inv_q;
  assign locked = (state_q == POL_HELD);
endmodule

// File: rtl/rxpol_xor.sv
// Zero-latency stream correction, one XOR per lane.
module rxpol_xor #(
  parameter int DATA_W = 1
) (
  input  logic              inv,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign out_data[g] = in_data[g] ^ inv;
  end
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/rx_polarity_lock.sv
module rx_polarity_lock #(
  parameter int LOCK_PKTS = 2,
  parameter int DATA_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              nlp_stb,
  input  logic              nlp_neg,
  input  logic              pkt_stb,
  input  logic              pkt_neg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              pol_inv,
  output logic              pol_locked
);
  logic link_fall, pkt_evt, nlp_evt;

  rxpol_evt u_evt (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .nlp_stb(nlp_stb), .pkt_stb(pkt_stb),
    .link_fall(link_fall), .pkt_evt(pkt_evt), .nlp_evt(nlp_evt)
  );

  rxpol_ctrl #(.LOCK_PKTS(LOCK_PKTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .link_fall(link_fall),
    .nlp_evt(nlp_evt), .nlp_neg(nlp_neg),
    .pkt_evt(pkt_evt), .pkt_neg(pkt_neg),
    .inv(pol_inv), .locked(pol_locked)
  );

  rxpol_xor #(.DATA_W(DATA_W)) u_xor (
    .inv(pol_inv), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );
endmodule

// File: rtl/rxpol_chk.sv
module rxpol_chk #(
  parameter int DATA_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_up,
  input logic              nlp_stb,
  input logic              pkt_stb,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              pol_inv,
  input logic              pol_locked
);
  logic lk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lk_q <= 1'b0;
    else        lk_q <= link_up;
  end

  // R6
  held_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_locked && link_up) |=> (pol_locked && $stable(pol_inv)));

  // R7
  link_loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_q && !link_up) |=> (!pol_locked && !pol_inv));

  // R4
  lock_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_locked) |-> $past(link_up));

  // R4
  lock_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_locked) |-> ($past(pkt_stb) || $past(link_up && !lk_q)));

  // R5
  inv_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol_inv) |-> $past(nlp_stb || pkt_stb || !link_up));

  // R9
  stream_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready)
    && ((out_data ^ in_data) == {DATA_W{pol_inv}}));
endmodule

bind rx_polarity_lock rxpol_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .nlp_stb(nlp_stb),
  .pkt_stb(pkt_stb), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .pol_inv(pol_inv), .pol_locked(pol_locked)
);

// File: tb/rx_polarity_lock_test.sv
module rx_polarity_lock_test;
  localparam int L = 2;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 0, nlp_stb = 0, nlp_neg = 0, pkt_stb = 0, pkt_neg = 0;
  logic in_valid = 0, out_ready = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, pol_inv, pol_locked;
  logic [W-1:0] out_data;

  always #5 clk = ~clk;

  rx_polarity_lock #(.LOCK_PKTS(L), .DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .nlp_stb(nlp_stb),
    .nlp_neg(nlp_neg), .pkt_stb(pkt_stb), .pkt_neg(pkt_neg),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .pol_inv(pol_inv), .pol_locked(pol_locked)
  );

  int vectors = 0, bad = 0;
  bit finished = 0;

  // model state
  bit m_dec = 0, m_inv = 0, m_lock = 0, m_lq = 0;
  int m_cnt = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_step(bit n, bit nn, bit p, bit pn, bit lk);
    if (m_lq && !lk) begin
      m_dec = 0; m_inv = 0; m_cnt = 0; m_lock = 0;
    end else if (!m_lock) begin
      if (p) begin
        if (!m_dec) begin m_dec = 1; m_inv = pn; m_cnt = 1; end
        else if (pn == m_inv) begin if (m_cnt < L) m_cnt++; end
        else begin m_inv = pn; m_cnt = 0; end
      end else if (n && !m_dec) begin
        m_dec = 1; m_inv = nn;
      end
      if (m_dec && lk && m_cnt == L) m_lock = 1;
    end
    m_lq = lk;
  endfunction

  // one cycle: check flags, drive, check stream, advance model
  task automatic step(string tag, bit n, bit nn, bit p, bit pn, bit lk);
    @(negedge clk);
    check({tag, " pol_inv"}, 32'(pol_inv), 32'(m_inv));
    check({tag, " pol_locked"}, 32'(pol_locked), 32'(m_lock));
    nlp_stb = n; nlp_neg = nn; pkt_stb = p; pkt_neg = pn; link_up = lk;
    in_valid = 1'($urandom); out_ready = 1'($urandom);
    in_data = W'($urandom);
    #1;
    check("R9 out_data", 32'(out_data), 32'(in_data ^ {W{m_inv}}));
    check("R9 handshake", {30'd0, out_valid, in_ready},
          {30'd0, in_valid, out_ready});
    model_step(n, nn, p, pn, lk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset inv", 32'(pol_inv), 0);
    check("R1 reset lock", 32'(pol_locked), 0);

    // R2: first pulse decides, later pulses ignored
    step("R2", 1, 1, 0, 0, 0);
    step("R2", 1, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 1);
    // R5: disagreeing packet flips and resets count
    step("R5", 0, 0, 1, 0, 1);
    // R4: two agreeing packets lock
    step("R4", 0, 0, 1, 0, 1);
    step("R4", 0, 0, 1, 0, 1);
    // R6: locked ignores strobes
    step("R6", 1, 1, 1, 1, 1);
    step("R6", 0, 0, 1, 1, 1);
    // R7: link loss with strobes in same cycle
    step("R7", 1, 1, 1, 1, 0);
    step("R7", 0, 0, 0, 0, 0);
    // R3 + R8: undecided, both strobes, packet wins
    step("R8", 1, 0, 1, 1, 0);
    step("R3", 0, 0, 1, 1, 0);
    // R10: count full while link low, lock when link rises
    step("R10", 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 1);
    step("R10", 0, 0, 0, 0, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit lk;
      lk = m_lq ? ($urandom_range(199) != 0) : ($urandom_range(14) == 0);
      step("R4 R5 R6 random", $urandom_range(7) == 0, $urandom_range(9) < 7,
           $urandom_range(8) == 0, $urandom_range(9) < 7, lk);
    end
    step("R7 end", 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R7 final inv", 32'(pol_inv), 32'(m_inv));
    check("R7 final lock", 32'(pol_locked), 32'(m_lock));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule